// File: doc/BRIEF.md
# Fractional Bit-Rate Generator with Mid-Bit Majority Sampler

This block turns one of several source-clock tick streams into a serial bit clock. The bit period is set by a 16-bit integer divisor N and an 8-bit stretch pattern. For each successive bit, one pattern bit is used, lowest bit first. A pattern bit of 1 lengthens that bit by one source tick. Over eight bits this gives an average divisor of N plus a fraction in eighths. Each bit period has two halves. The bit clock is low for the first half and high for the second. At bit end it falls and the next bit begins.

The same timing recovers received data. Within every bit, the serial input is sampled on three consecutive source ticks around the middle of the bit. The majority value of those three samples is registered, and a one-cycle strobe marks it. A bit-start pulse, typically from start-edge detection, realigns the timing to the incoming frame. It also loads any configuration written since the previous bit-start.

All logic runs on a single system clock. The source clocks arrive as tick enables.

Top module: `frac_baud_sampler`

## Requirements
- R1: After reset, bit_clk, sample_stb and rx_bit are 0, and no timing runs until the first bit_start, even if ticks arrive and registers are written.
- R2: Only ticks from the selected source advance the timing: src_sel 2'b00 picks ext_tick, 2'b01 picks aux_tick, and both 2'b10 and 2'b11 pick sys_tick.
- R3: With divisor N = {high byte, low byte}, where wr_div_byte[1] writes the high byte and wr_div_byte[0] the low byte, bit_clk is low for floor(N/2)+(N mod 2) ticks. It is then high for floor(N/2)+m ticks and falls at bit end, so each bit lasts N+m ticks.
- R4: The stretch bit m of a bit is bit k of the captured pattern byte, where k is the bit's index since the last bit_start, taken modulo 8. k starts at 0 and wraps from 7 back to 0.
- R5: Ticks within a bit are numbered from 0. rx_bit becomes the majority of rxd sampled on ticks floor(N/2)-1, floor(N/2) and floor(N/2)+1.
- R6: sample_stb is high for exactly one clock cycle. That cycle directly follows tick floor(N/2)+1, and it is the same cycle in which rx_bit takes its new value.
- R7: Writes to the divisor or pattern registers go to holding registers and do not change the bit in progress. They take effect at the next bit_start, including a write made in the same cycle as that bit_start.
- R8: If N is below 3 when bit_start arrives, the timing stays idle. bit_clk stays 0 and no sample_stb occurs until a bit_start with a valid N.
- R9: bit_start forces bit_clk to 0, ignores any tick in its own cycle, and restarts counting. The first bit therefore ends exactly N+m ticks after the bit_start cycle.
- R10: When the strobe tick is also the last tick of a bit (N=3, m=0), both actions take place on that tick: sample_stb rises and bit_clk falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_sel | input | 2 | Source tick select |
| ext_tick | input | 1 | External source tick enable |
| aux_tick | input | 1 | Auxiliary source tick enable |
| sys_tick | input | 1 | Subsystem source tick enable |
| wr_data | input | 8 | Data byte for register writes |
| wr_div_byte | input | DIV_BYTES | Per-byte divisor write strobes, bit 0 = low byte |
| wr_mod | input | 1 | Stretch-pattern write strobe |
| bit_start | input | 1 | Restart and configuration load pulse |
| rxd | input | 1 | Serial receive line |
| bit_clk | output | 1 | Generated bit clock |
| sample_stb | output | 1 | One-cycle strobe when rx_bit is updated |
| rx_bit | output | 1 | Majority-voted received bit |

## Verification
The two actions that can fall on the same tick are the sampling strobe and the end of a bit, which falls bit_clk and advances the pattern pointer. With N=3 and a zero pattern, the late sample tick is also the last tick of every bit. The bench runs that setup and requires rising strobes to coincide with bit_clk falls. A second overlap puts a register write and bit_start in the same cycle. Here the bench expects the first bit length to follow the freshly written value. A behavioural model that counts tick positions with plain integers is compared with every output on every clock.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  localparam int BYTE_W  = 8;
  localparam int PTR_W   = 3;
  localparam int MIN_DIV = 3;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'b00,
    SRC_AUX  = 2'b01,
    SRC_SYS  = 2'b10,
    SRC_SYS2 = 2'b11
  } src_sel_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/fbs_rst_sync.sv
module fbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/fbs_src_mux.sv
module fbs_src_mux
  import fbs_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       ext_tick,
  input  logic       aux_tick,
  input  logic       sys_tick,
  output logic       tick
);

  always_comb begin
    case (src_sel_e'(sel))
      SRC_EXT: tick = ext_tick;
      SRC_AUX: tick = aux_tick;
      default: tick = sys_tick;
    endcase
  end

endmodule

// File: rtl/fbs_cfg_regs.sv
module fbs_cfg_regs
  import fbs_pkg::*;
#(
  parameter int DIV_BYTES = 2,
  parameter int DIV_W     = DIV_BYTES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BYTE_W-1:0]    wr_data,
  input  logic [DIV_BYTES-1:0] wr_div_byte,
  input  logic                 wr_mod,
  input  logic                 bit_start,
  output logic [DIV_W-1:0]     div_act,
  output logic [BYTE_W-1:0]    mod_act,
  output logic                 run_ok
);

  logic [DIV_W-1:0]  div_sh_q, div_sh_d;
  logic [DIV_W-1:0]  div_act_q, div_act_d;
  logic [BYTE_W-1:0] mod_sh_q, mod_sh_d;
  logic [BYTE_W-1:0] mod_act_q, mod_act_d;
  logic              run_q, run_d;

  // holding register: each byte lane has its own write strobe
  for (genvar b = 0; b < DIV_BYTES; b++) begin : g_lane
    assign div_sh_d[b*BYTE_W +: BYTE_W] =
      wr_div_byte[b] ? wr_data : div_sh_q[b*BYTE_W +: BYTE_W];
  end

  always_comb begin
    mod_sh_d  = wr_mod ? wr_data : mod_sh_q;
    div_act_d = div_act_q;
    mod_act_d = mod_act_q;
    run_d     = run_q;
    if (bit_start) begin
      // same-cycle writes are included in what gets captured
      div_act_d = div_sh_d;
      mod_act_d = mod_sh_d;
      run_d     = (div_sh_d >= DIV_W'(MIN_DIV));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sh_q  <= '0;
      div_act_q <= '0;
      mod_sh_q  <= '0;
      mod_act_q <= '0;
      run_q     <= 1'b0;
    end else begin
      div_sh_q  <= div_sh_d;
      div_act_q <= div_act_d;
      mod_sh_q  <= mod_sh_d;
      mod_act_q <= mod_act_d;
      run_q     <= run_d;
    end
  end

  assign div_act = div_act_q;
  assign mod_act = mod_act_q;
  assign run_ok  = run_q;

endmodule

// File: rtl/fbs_half_timer.sv
module fbs_half_timer
  import fbs_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              adv,
  input  logic [DIV_W-1:0]  div_act,
  input  logic [BYTE_W-1:0] mod_act,
  output logic              bit_clk,
  output logic              bit_end,
  output logic [PTR_W-1:0]  mod_ptr
);

  logic [DIV_W-1:0] half_len, low_len, high_len, cur_cnt;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             bclk_q, bclk_d;
  logic             cur_m, last_tick;

  always_comb begin
    half_len  = div_act >> 1;
    cur_m     = mod_act[ptr_q];
    low_len   = half_len + DIV_W'(div_act[0]);
    high_len  = half_len + DIV_W'(cur_m);
    // a zero count means the first low half has not been loaded yet
    cur_cnt   = (cnt_q == '0) ? low_len : cnt_q;
    last_tick = (cur_cnt == DIV_W'(1));
  end

  always_comb begin
    cnt_d  = cnt_q;
    ptr_d  = ptr_q;
    bclk_d = bclk_q;
    if (restart) begin
      cnt_d  = '0;
      ptr_d  = '0;
      bclk_d = 1'b0;
    end else if (adv) begin
      if (last_tick) begin
        if (!bclk_q) begin
          bclk_d = 1'b1;
          cnt_d  = high_len;
        end else begin
          bclk_d = 1'b0;
          cnt_d  = low_len;
          ptr_d  = ptr_q + PTR_W'(1);
        end
      end else begin
        cnt_d = cur_cnt - DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ptr_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ptr_q  <= ptr_d;
      bclk_q <= bclk_d;
    end
  end

  assign bit_end = adv & ~restart & bclk_q & last_tick;
  assign bit_clk = bclk_q;
  assign mod_ptr = ptr_q;

endmodule

// File: rtl/fbs_mid_sampler.sv
module fbs_mid_sampler
  import fbs_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             adv,
  input  logic             bit_end,
  input  logic [DIV_W-1:0] div_act,
  input  logic             rxd,
  output logic             sample_stb,
  output logic             rx_bit
);

  logic [DIV_W-1:0] half_len;
  logic [DIV_W-1:0] pos_q, pos_d;
  logic             s_early_q, s_early_d;
  logic             s_mid_q, s_mid_d;
  logic             rx_q, rx_d;
  logic             stb_q, stb_d;
  logic             hit_early, hit_mid, hit_late;

  always_comb begin
    half_len  = div_act >> 1;
    hit_early = (pos_q == half_len - DIV_W'(1));
    hit_mid   = (pos_q == half_len);
    hit_late  = (pos_q == half_len + DIV_W'(1));
  end

  always_comb begin
    pos_d     = pos_q;
    s_early_d = s_early_q;
    s_mid_d   = s_mid_q;
    rx_d      = rx_q;
    stb_d     = 1'b0;
    if (restart) begin
      pos_d = '0;
    end else if (adv) begin
      pos_d = bit_end ? '0 : pos_q + DIV_W'(1);
      if (hit_early) s_early_d = rxd;
      if (hit_mid)   s_mid_d   = rxd;
      if (hit_late) begin
        rx_d  = vote3(s_early_q, s_mid_q, rxd);
        stb_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      s_early_q <= 1'b0;
      s_mid_q   <= 1'b0;
      rx_q      <= 1'b0;
      stb_q     <= 1'b0;
    end else begin
      pos_q     <= pos_d;
      s_early_q <= s_early_d;
      s_mid_q   <= s_mid_d;
      rx_q      <= rx_d;
      stb_q     <= stb_d;
    end
  end

  assign sample_stb = stb_q;
  assign rx_bit     = rx_q;

endmodule

// File: rtl/frac_baud_sampler.sv
module frac_baud_sampler
  import fbs_pkg::*;
#(
  parameter int DIV_BYTES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           src_sel,
  input  logic                 ext_tick,
  input  logic                 aux_tick,
  input  logic                 sys_tick,
  input  logic [BYTE_W-1:0]    wr_data,
  input  logic [DIV_BYTES-1:0] wr_div_byte,
  input  logic                 wr_mod,
  input  logic                 bit_start,
  input  logic                 rxd,
  output logic                 bit_clk,
  output logic                 sample_stb,
  output logic                 rx_bit
);

  localparam int DIV_W = DIV_BYTES * BYTE_W;

  logic              srst_n;
  logic              tick;
  logic              adv;
  logic              run_ok;
  logic              bit_end;
  logic [DIV_W-1:0]  div_act;
  logic [BYTE_W-1:0] mod_act;
  logic [PTR_W-1:0]  mod_ptr;

  fbs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  fbs_src_mux u_mux (
    .sel      (src_sel),
    .ext_tick (ext_tick),
    .aux_tick (aux_tick),
    .sys_tick (sys_tick),
    .tick     (tick)
  );

  fbs_cfg_regs #(.DIV_BYTES(DIV_BYTES), .DIV_W(DIV_W)) u_cfg (
    .clk         (clk),
    .rst_n       (srst_n),
    .wr_data     (wr_data),
    .wr_div_byte (wr_div_byte),
    .wr_mod      (wr_mod),
    .bit_start   (bit_start),
    .div_act     (div_act),
    .mod_act     (mod_act),
    .run_ok      (run_ok)
  );

  // a tick in the restart cycle is dropped
  assign adv = tick & run_ok & ~bit_start;

  fbs_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst_n   (srst_n),
    .restart (bit_start),
    .adv     (adv),
    .div_act (div_act),
    .mod_act (mod_act),
    .bit_clk (bit_clk),
    .bit_end (bit_end),
    .mod_ptr (mod_ptr)
  );

  fbs_mid_sampler #(.DIV_W(DIV_W)) u_samp (
    .clk        (clk),
    .rst_n      (srst_n),
    .restart    (bit_start),
    .adv        (adv),
    .bit_end    (bit_end),
    .div_act    (div_act),
    .rxd        (rxd),
    .sample_stb (sample_stb),
    .rx_bit     (rx_bit)
  );

endmodule

// File: rtl/fbs_checker.sv
module fbs_checker
  import fbs_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_start,
  input logic              adv,
  input logic              bit_end,
  input logic              run_ok,
  input logic              bit_clk,
  input logic              sample_stb,
  input logic              rx_bit,
  input logic [PTR_W-1:0]  mod_ptr,
  input logic [DIV_W-1:0]  div_act,
  input logic [BYTE_W-1:0] mod_act
);

  p_gate_by_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !bit_start) |=> $stable(bit_clk));

  p_fall_at_bit_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bit_clk) |-> $past(bit_end || bit_start));

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> (mod_ptr == PTR_W'($past(mod_ptr) + PTR_W'(1))));

  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_end && !bit_start) |=> $stable(mod_ptr));

  p_vote_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |-> $stable(rx_bit));

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_start |=> ($stable(div_act) && $stable(mod_act)));

  p_idle_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |-> (!bit_clk && !sample_stb));

  p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |=> (!bit_clk && !sample_stb && mod_ptr == '0));

  p_coincide_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && div_act == DIV_W'(3) && !mod_act[mod_ptr]) |=> (sample_stb && !bit_clk));

endmodule

bind frac_baud_sampler fbs_checker #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (srst_n),
  .bit_start  (bit_start),
  .adv        (adv),
  .bit_end    (bit_end),
  .run_ok     (run_ok),
  .bit_clk    (bit_clk),
  .sample_stb (sample_stb),
  .rx_bit     (rx_bit),
  .mod_ptr    (mod_ptr),
  .div_act    (div_act),
  .mod_act    (mod_act)
);

// File: tb/frac_baud_sampler_bench.sv
module frac_baud_sampler_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] src_sel = 2'b10;
  logic       ext_tick = 1'b0, aux_tick = 1'b0, sys_tick = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] wr_div_byte = 2'b00;
  logic       wr_mod = 1'b0;
  logic       bit_start = 1'b0;
  logic       rxd = 1'b0;
  logic       bit_clk, sample_stb, rx_bit;

  frac_baud_sampler u_frac_baud_sampler (
    .clk (clk), .rst_n (rst_n), .src_sel (src_sel),
    .ext_tick (ext_tick), .aux_tick (aux_tick), .sys_tick (sys_tick),
    .wr_data (wr_data), .wr_div_byte (wr_div_byte), .wr_mod (wr_mod),
    .bit_start (bit_start), .rxd (rxd),
    .bit_clk (bit_clk), .sample_stb (sample_stb), .rx_bit (rx_bit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  bit chk_en = 0;
  bit ext_on = 0, aux_on = 0, sys_on = 0, rx_rand = 0, rx_level = 0;
  logic [15:0] lfsr = 16'hACE1;
  int falls[$];
  int stb_cnt = 0, coinc = 0, c0 = 0;
  bit prev_bclk = 0;

  // reference model state
  int m_sy1 = 0, m_sy2 = 0;
  int sh_div = 0, sh_mod = 0, act_div = 0, act_mod = 0;
  int m_run = 0, m_pos = 0, m_ptr = 0;
  bit m_bclk = 0, m_stb = 0, m_rx = 0, m_s0 = 0, m_s1 = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // cycle model: tick positions counted with integers
  always @(posedge clk) begin
    int nd, nm, h, r, mb, plen, llen;
    bit tk, in_rst;
    cyc++;
    in_rst = (m_sy2 == 0);
    m_sy2 = m_sy1;
    m_sy1 = 1;
    if (!rst_n) begin
      m_sy1 = 0; m_sy2 = 0; in_rst = 1;
    end
    if (in_rst) begin
      sh_div = 0; sh_mod = 0; act_div = 0; act_mod = 0;
      m_run = 0; m_pos = 0; m_ptr = 0;
      m_bclk = 0; m_stb = 0; m_rx = 0; m_s0 = 0; m_s1 = 0;
    end else begin
      nd = sh_div;
      if (wr_div_byte[0]) nd = (nd & 32'hFF00) | int'(wr_data);
      if (wr_div_byte[1]) nd = (nd & 32'h00FF) | (int'(wr_data) << 8);
      nm = wr_mod ? int'(wr_data) : sh_mod;
      tk = (src_sel == 2'b00) ? ext_tick : (src_sel == 2'b01) ? aux_tick : sys_tick;
      m_stb = 0;
      if (bit_start) begin
        act_div = nd; act_mod = nm; m_run = (nd >= 3) ? 1 : 0;
        m_pos = 0; m_bclk = 0; m_ptr = 0;
      end else if (m_run != 0 && tk) begin
        h = act_div / 2; r = act_div % 2;
        mb = (act_mod >> m_ptr) & 1;
        plen = act_div + mb; llen = h + r;
        if (m_pos == h - 1) m_s0 = rxd;
        if (m_pos == h)     m_s1 = rxd;
        if (m_pos == h + 1) begin
          m_rx = ((int'(m_s0) + int'(m_s1) + int'(rxd)) >= 2);
          m_stb = 1;
        end
        m_pos++;
        if (m_pos == llen) m_bclk = 1;
        if (m_pos == plen) begin
          m_bclk = 0; m_pos = 0; m_ptr = (m_ptr + 1) % 8;
        end
      end
      sh_div = nd; sh_mod = nm;
    end
  end

  // per-cycle comparison and event monitor
  always @(negedge clk) begin
    if (chk_en) begin
      chk(bit_clk === m_bclk, "R3 bit_clk", int'(bit_clk), int'(m_bclk));
      chk(sample_stb === m_stb, "R6 sample_stb", int'(sample_stb), int'(m_stb));
      chk(rx_bit === m_rx, "R5 rx_bit", int'(rx_bit), int'(m_rx));
      if (prev_bclk && !bit_clk) begin
        falls.push_back(cyc);
        if (sample_stb) coinc++;
      end
      if (sample_stb) stb_cnt++;
      prev_bclk = bit_clk;
    end
  end

  // tick sources and receive line
  always @(negedge clk) begin
    ext_tick = ext_on && (cyc % 3 == 0);
    aux_tick = aux_on && (cyc % 2 == 1);
    sys_tick = sys_on;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rxd = rx_rand ? lfsr[0] : rx_level;
  end

  task automatic wr_reg(input int sel, input logic [7:0] val);
    @(negedge clk);
    wr_data = val;
    if (sel == 0) wr_div_byte = 2'b01;
    else if (sel == 1) wr_div_byte = 2'b10;
    else wr_mod = 1'b1;
    @(negedge clk);
    wr_div_byte = 2'b00;
    wr_mod = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk);
    bit_start = 1'b1;
    @(negedge clk);
    bit_start = 1'b0;
    c0 = cyc;
    @(negedge clk);
    falls.delete();
  endtask

  task automatic wait_falls(input int n);
    while (falls.size() < n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int s;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    chk_en = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(bit_clk == 1'b0, "R1 bit_clk after reset", int'(bit_clk), 0);
    chk(sample_stb == 1'b0, "R1 sample_stb after reset", int'(sample_stb), 0);
    chk(rx_bit == 1'b0, "R1 rx_bit after reset", int'(rx_bit), 0);
    src_sel = 2'b10; sys_on = 1;
    wr_reg(0, 8'd8); wr_reg(1, 8'd0); wr_reg(2, 8'h85);
    s = stb_cnt;
    repeat (30) @(negedge clk);
    chk(stb_cnt == s, "R1 idle before first bit_start", stb_cnt - s, 0);
    chk(bit_clk == 1'b0, "R1 bit_clk idle", int'(bit_clk), 0);

    // R4 / R7 / R9: pattern 0x85 on N=8, mid-run rewrite held off
    rx_rand = 1;
    do_start();
    wait_falls(4);
    wr_reg(0, 8'd5); wr_reg(2, 8'hFF);
    wait_falls(12);
    chk(falls[0] - c0 == 9, "R9 first bit aligned to bit_start", falls[0] - c0, 9);
    for (int k = 1; k < 12; k++) begin
      int exp_len;
      exp_len = 8 + ((8'h85 >> (k % 8)) & 1);
      chk(falls[k] - falls[k-1] == exp_len, "R4 stretched bit length (R7 held)",
          falls[k] - falls[k-1], exp_len);
    end
    // R7: the new values take effect at bit_start
    do_start();
    wait_falls(4);
    chk(falls[0] - c0 == 6, "R7 new divisor after bit_start", falls[0] - c0, 6);
    for (int k = 1; k < 4; k++)
      chk(falls[k] - falls[k-1] == 6, "R7 new pattern after bit_start", falls[k] - falls[k-1], 6);

    // R5: steady line levels
    rx_rand = 0; rx_level = 1;
    repeat (30) @(negedge clk);
    chk(rx_bit == 1'b1, "R5 vote of ones", int'(rx_bit), 1);
    rx_level = 0;
    repeat (30) @(negedge clk);
    chk(rx_bit == 1'b0, "R5 vote of zeros", int'(rx_bit), 0);

    // R2: source selection
    rx_rand = 1; ext_on = 1; aux_on = 0; src_sel = 2'b01;
    do_start();
    s = stb_cnt;
    repeat (40) @(negedge clk);
    chk(stb_cnt == s, "R2 unselected ticks ignored", stb_cnt - s, 0);
    chk(bit_clk == 1'b0, "R2 bit_clk still low", int'(bit_clk), 0);
    aux_on = 1;
    s = stb_cnt;
    repeat (200) @(negedge clk);
    chk(stb_cnt - s >= 10, "R2 aux source drives timing", stb_cnt - s, 10);
    src_sel = 2'b00;
    do_start();
    repeat (200) @(negedge clk);
    src_sel = 2'b11;
    do_start();
    s = stb_cnt;
    repeat (100) @(negedge clk);
    chk(stb_cnt - s >= 14, "R2 select 11 uses subsystem ticks", stb_cnt - s, 14);
    src_sel = 2'b10;

    // R8: invalid divisor
    wr_reg(0, 8'd2);
    do_start();
    s = stb_cnt;
    repeat (60) @(negedge clk);
    chk(stb_cnt == s, "R8 no strobe for N<3", stb_cnt - s, 0);
    chk(bit_clk == 1'b0, "R8 bit_clk idle for N<3", int'(bit_clk), 0);

    // R10: N=3, zero pattern, strobe and fall coincide
    wr_reg(0, 8'd3); wr_reg(2, 8'h00);
    do_start();
    s = stb_cnt;
    begin
      int co;
      co = coinc;
      repeat (60) @(negedge clk);
      chk(coinc - co >= 18, "R10 strobe on falling bit_clk", coinc - co, 18);
    end
    chk(stb_cnt - s >= 18, "R6 one strobe per bit", stb_cnt - s, 18);

    // R7: write in the same cycle as bit_start
    @(negedge clk);
    wr_data = 8'd7; wr_div_byte = 2'b01; bit_start = 1'b1;
    @(negedge clk);
    wr_div_byte = 2'b00; bit_start = 1'b0; c0 = cyc;
    @(negedge clk);
    falls.delete();
    wait_falls(2);
    chk(falls[0] - c0 == 7, "R7 same-cycle write captured", falls[0] - c0, 7);
    chk(falls[1] - falls[0] == 7, "R7 same-cycle write second bit", falls[1] - falls[0], 7);

    // R9: restart while bit_clk is high
    wr_reg(0, 8'd8);
    do_start();
    while (bit_clk != 1'b1) @(negedge clk);
    do_start();
    chk(bit_clk == 1'b0, "R9 restart forces bit_clk low", int'(bit_clk), 0);
    wait_falls(1);
    chk(falls[0] - c0 == 8, "R9 realigned bit length", falls[0] - c0, 8);

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule